// File: doc/BRIEF.md
# Repeating DMA Channel with Half-Count Interrupt

This block is one DMA channel that carries 32-bit words from a peripheral data register into a memory area. Each peripheral request causes one word transfer. The transfer reads the source and then writes the destination, and it does so through a simple single-word bus master port with a request/acknowledge handshake. Software sets up the channel through a small indexed register port. That port holds the source address, the destination address, the remaining count, read-only copies of the destination and count backups, and a control/status word.

In repeat mode the channel becomes a hardware double buffer. When the count has dropped to half of its starting value, a half-done flag is raised, so software can process the first half of the area. When the count reaches zero, a done flag is raised. The destination address and the count then reload from their backups, and transfers continue into the first half again without any reprogramming. If software has not acknowledged an event before the same event comes round again, the channel stops and reports an overrun, and the data waiting in the area is not overwritten.

Top module: `dma_rpt_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `bus_req` is 0. The register indices are: 0 source, 1 destination, 2 count, 3 destination backup (read-only), 4 count backup (read-only), 5 control/status. The control/status word uses these bits: bit 0 enable, bit 1 interrupt enable, bit 2 half interrupt enable, bits 4:3 source mode, bits 6:5 destination mode, bits 9:7 repeat code, bit 16 half-done flag, bit 17 done flag, bit 18 overrun flag.
- R2: A transfer starts when `periph_req` is high while the channel is idle and ready. It produces exactly one read at the source address, followed by one write at the destination address that carries the data that was read. The count decrements on the cycle the write is acknowledged.
- R3: Address mode 00 keeps an address fixed, 01 adds 4 after each transfer, and 10 subtracts 4. The source and destination each have their own mode field.
- R4: When a transfer leaves the count equal to floor(backup count / 2), and that value is nonzero, the half-done flag is set.
- R5: When a transfer leaves the count at 0, the done flag is set. Unless repeat mode is selected, the enable bit is cleared and later requests cause no bus activity.
- R6: With repeat code 010, the transfer that leaves the count at 0 also reloads the destination from its backup and the count from its backup. The channel stays enabled.
- R7: A write to the source, destination or count while the channel is disabled also loads the matching backup (destination or count). Such writes are ignored while the channel is enabled.
- R8: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. If a hardware set falls in the same cycle as a software clear of the same flag, the flag ends up set, and the clear counts as the acknowledgement for overrun purposes.
- R9: If a half-count or terminal-count event occurs while its own flag is still set, the channel sets the overrun flag and clears the enable bit. No reload takes place.
- R10: `irq` is high exactly when interrupt enable is set and at least one of these holds: the done flag is set, the overrun flag is set, or the half-done flag and half interrupt enable are both set.
- R11: While `dma_glb_en` is low or `abort_in` is high, no new transfer starts. A cycle with `abort_in` high clears the enable bit.
- R12: `bus_req` stays high, and `bus_we` keeps its value, until `bus_ack` arrives. `bus_we` is 0 in the read phase and 1 in the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_widx | input | 3 | Register write index |
| reg_wdata | input | DW | Register write data |
| reg_ridx | input | 3 | Register read index |
| reg_rdata | output | DW | Register read data (combinational) |
| dma_glb_en | input | 1 | Global DMA enable |
| abort_in | input | 1 | Non-maskable abort |
| periph_req | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| irq | output | 1 | Channel interrupt |

## Verification
Two things can fall in the same cycle: a software write that clears a status flag, and the acknowledged write of a transfer that sets that same flag again. To provoke this, the bench leaves the half-done flag set through a full repeat round and then times a control write to land on exactly the edge where the sixth write is acknowledged. It confirms the coincidence by sampling the bus handshake at that moment. The result must be the flag set and no overrun. By contrast, a later terminal count that arrives while the done flag is still set, with no clear, must halt the channel with overrun and no reload.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;

   typedef enum logic [1:0] {
      AM_FIXED = 2'b00,
      AM_INC   = 2'b01,
      AM_DEC   = 2'b10,
      AM_RSVD  = 2'b11
   } addr_mode_e;

   typedef enum logic [1:0] {
      XS_IDLE = 2'b00,
      XS_RD   = 2'b01,
      XS_WR   = 2'b10
   } xfer_state_e;

   localparam logic [2:0] RPT_DST = 3'b010;

   localparam logic [2:0] IDX_SRC  = 3'd0;
   localparam logic [2:0] IDX_DST  = 3'd1;
   localparam logic [2:0] IDX_CNT  = 3'd2;
   localparam logic [2:0] IDX_DSTB = 3'd3;
   localparam logic [2:0] IDX_CNTB = 3'd4;
   localparam logic [2:0] IDX_CTL  = 3'd5;

   localparam int B_EN  = 0;
   localparam int B_IE  = 1;
   localparam int B_HIE = 2;
   localparam int B_SM  = 3;
   localparam int B_DM  = 5;
   localparam int B_RPT = 7;
   localparam int B_HF  = 16;
   localparam int B_EF  = 17;
   localparam int B_OV  = 18;

endpackage

// File: rtl/dma_rpt_step.sv
module dma_rpt_step
   import dma_rpt_pkg::*;
#(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic [AW-1:0] cur,
   input  logic [1:0]    mode,
   output logic [AW-1:0] nxt
);

   localparam logic [AW-1:0] DELTA = AW'(STEP);

   always_comb begin
      case (addr_mode_e'(mode))
         AM_INC:  nxt = cur + DELTA;
         AM_DEC:  nxt = cur - DELTA;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/dma_rpt_regs.sv
module dma_rpt_regs
   import dma_rpt_pkg::*;
#(
   parameter int DW   = 32,
   parameter int AW   = 32,
   parameter int CW   = 16,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [2:0]    rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          xfer_done,
   input  logic          abort,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic          cnt_nz,
   output logic          chan_en,
   output logic          irq
);

   localparam int            NSTEP   = 2;
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic [AW-1:0] src_q, dst_q, dstb_q, src_n, dst_n, dstb_n;
   logic [CW-1:0] cnt_q, cntb_q, cnt_n, cntb_n;
   logic          en_q, ie_q, hie_q, en_n, ie_n, hie_n;
   logic [1:0]    sm_q, dm_q, sm_n, dm_n;
   logic [2:0]    rpt_q, rpt_n;
   logic          hf_q, ef_q, ov_q, hf_n, ef_n, ov_n;

   logic [AW-1:0] step_cur  [NSTEP];
   logic [1:0]    step_mode [NSTEP];
   logic [AW-1:0] step_nxt  [NSTEP];

   assign step_cur[0]  = src_q;
   assign step_mode[0] = sm_q;
   assign step_cur[1]  = dst_q;
   assign step_mode[1] = dm_q;

   for (genvar g = 0; g < NSTEP; g++) begin : g_step
      dma_rpt_step #(.AW(AW), .STEP(STEP)) u_step (
         .cur  (step_cur[g]),
         .mode (step_mode[g]),
         .nxt  (step_nxt[g])
      );
   end

   logic [CW-1:0] cnt_dec, half_pt;
   logic          half_evt, tc_evt, wr_prim, wr_ctl;
   logic          hf_eff, ef_eff, ov_eff;

   assign cnt_dec  = cnt_q - CNT_ONE;
   assign half_pt  = cntb_q >> 1;
   assign half_evt = xfer_done && (cnt_dec == half_pt) && (half_pt != '0);
   assign tc_evt   = xfer_done && (cnt_dec == '0);
   assign wr_prim  = wr_en && !en_q;
   assign wr_ctl   = wr_en && (wr_idx == IDX_CTL);
   assign hf_eff   = hf_q && !(wr_ctl && !wr_data[B_HF]);
   assign ef_eff   = ef_q && !(wr_ctl && !wr_data[B_EF]);
   assign ov_eff   = ov_q && !(wr_ctl && !wr_data[B_OV]);

   always_comb begin
      src_n  = src_q;
      dst_n  = dst_q;
      dstb_n = dstb_q;
      cnt_n  = cnt_q;
      cntb_n = cntb_q;
      en_n   = en_q;
      ie_n   = ie_q;
      hie_n  = hie_q;
      sm_n   = sm_q;
      dm_n   = dm_q;
      rpt_n  = rpt_q;
      hf_n   = hf_eff;
      ef_n   = ef_eff;
      ov_n   = ov_eff;
      if (wr_prim) begin
         case (wr_idx)
            IDX_SRC: src_n = wr_data[AW-1:0];
            IDX_DST: begin
               dst_n  = wr_data[AW-1:0];
               dstb_n = wr_data[AW-1:0];
            end
            IDX_CNT: begin
               cnt_n  = wr_data[CW-1:0];
               cntb_n = wr_data[CW-1:0];
            end
            default: ;
         endcase
      end
      if (wr_ctl) begin
         en_n  = wr_data[B_EN];
         ie_n  = wr_data[B_IE];
         hie_n = wr_data[B_HIE];
         sm_n  = wr_data[B_SM+:2];
         dm_n  = wr_data[B_DM+:2];
         rpt_n = wr_data[B_RPT+:3];
      end
      if (xfer_done) begin
         src_n = step_nxt[0];
         dst_n = step_nxt[1];
         cnt_n = cnt_dec;
         if (half_evt) begin
            if (hf_eff) begin
               ov_n = 1'b1;
               en_n = 1'b0;
            end else begin
               hf_n = 1'b1;
            end
         end
         if (tc_evt) begin
            if (ef_eff) begin
               ov_n = 1'b1;
               en_n = 1'b0;
            end else begin
               ef_n = 1'b1;
               if (rpt_q == RPT_DST) begin
                  dst_n = dstb_q;
                  cnt_n = cntb_q;
               end else begin
                  en_n = 1'b0;
               end
            end
         end
      end
      if (abort) en_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         dstb_q <= '0;
         cnt_q  <= '0;
         cntb_q <= '0;
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         hie_q  <= 1'b0;
         sm_q   <= '0;
         dm_q   <= '0;
         rpt_q  <= '0;
         hf_q   <= 1'b0;
         ef_q   <= 1'b0;
         ov_q   <= 1'b0;
      end else begin
         src_q  <= src_n;
         dst_q  <= dst_n;
         dstb_q <= dstb_n;
         cnt_q  <= cnt_n;
         cntb_q <= cntb_n;
         en_q   <= en_n;
         ie_q   <= ie_n;
         hie_q  <= hie_n;
         sm_q   <= sm_n;
         dm_q   <= dm_n;
         rpt_q  <= rpt_n;
         hf_q   <= hf_n;
         ef_q   <= ef_n;
         ov_q   <= ov_n;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         IDX_SRC:  rd_data[AW-1:0] = src_q;
         IDX_DST:  rd_data[AW-1:0] = dst_q;
         IDX_CNT:  rd_data[CW-1:0] = cnt_q;
         IDX_DSTB: rd_data[AW-1:0] = dstb_q;
         IDX_CNTB: rd_data[CW-1:0] = cntb_q;
         IDX_CTL: begin
            rd_data[B_EN]      = en_q;
            rd_data[B_IE]      = ie_q;
            rd_data[B_HIE]     = hie_q;
            rd_data[B_SM+:2]   = sm_q;
            rd_data[B_DM+:2]   = dm_q;
            rd_data[B_RPT+:3]  = rpt_q;
            rd_data[B_HF]      = hf_q;
            rd_data[B_EF]      = ef_q;
            rd_data[B_OV]      = ov_q;
         end
         default: ;
      endcase
   end

   assign src_addr = src_q;
   assign dst_addr = dst_q;
   assign cnt_nz   = (cnt_q != '0);
   assign chan_en  = en_q;
   assign irq      = ie_q && (ef_q || ov_q || (hie_q && hf_q));

   p_abort_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !en_q);

   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_done && !(wr_prim && wr_idx == IDX_CNT)) |=> $stable(cnt_q));

   p_half_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hf_q) |-> $past(xfer_done));

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      half_evt |=> hf_q);

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt && rpt_q == RPT_DST && !ef_eff) |=>
         (cnt_q == $past(cntb_q) && dst_q == $past(dstb_q)));

   p_ovr_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_q) |-> !en_q);

endmodule

// File: rtl/dma_rpt_xfer.sv
module dma_rpt_xfer
   import dma_rpt_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          req,
   input  logic [AW-1:0] src_addr,
   input  logic [AW-1:0] dst_addr,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ack,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          done
);

   xfer_state_e   state_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         data_q  <= '0;
      end else begin
         case (state_q)
            XS_IDLE: if (go && req) state_q <= XS_RD;
            XS_RD: begin
               if (bus_ack) begin
                  data_q  <= bus_rdata;
                  state_q <= XS_WR;
               end
            end
            XS_WR: if (bus_ack) state_q <= XS_IDLE;
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign bus_req   = (state_q != XS_IDLE);
   assign bus_we    = (state_q == XS_WR);
   assign bus_addr  = bus_we ? dst_addr : src_addr;
   assign bus_wdata = data_q;
   assign done      = bus_we && bus_ack;

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we)));

   p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !$past(bus_we)) |-> $past(bus_ack));

endmodule

// File: rtl/dma_rpt_chan.sv
module dma_rpt_chan
   import dma_rpt_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_widx,
   input  logic [DW-1:0] reg_wdata,
   input  logic [2:0]    reg_ridx,
   output logic [DW-1:0] reg_rdata,
   input  logic          dma_glb_en,
   input  logic          abort_in,
   input  logic          periph_req,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ack,
   output logic          irq
);

   localparam int STEP = DW / 8;

   initial begin
      assert (DW % 8 == 0) else $error("DW must be a whole number of bytes");
      assert (DW > B_OV)   else $error("DW too narrow for control word");
      assert (AW <= DW)    else $error("AW must not exceed DW");
      assert (CW >= 2 && CW <= DW) else $error("CW out of range");
   end

   logic [AW-1:0] src_addr, dst_addr;
   logic          cnt_nz, chan_en, done, go;

   assign go = chan_en && dma_glb_en && !abort_in && cnt_nz;

   dma_rpt_regs #(.DW(DW), .AW(AW), .CW(CW), .STEP(STEP)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .wr_idx    (reg_widx),
      .wr_data   (reg_wdata),
      .rd_idx    (reg_ridx),
      .rd_data   (reg_rdata),
      .xfer_done (done),
      .abort     (abort_in),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .cnt_nz    (cnt_nz),
      .chan_en   (chan_en),
      .irq       (irq)
   );

   dma_rpt_xfer #(.DW(DW), .AW(AW)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .req       (periph_req),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .done      (done)
   );

   p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && (!dma_glb_en || abort_in)) |=> !bus_req);

endmodule

// File: tb/dma_rpt_chan_tb.sv
`timescale 1ns/1ps
module dma_rpt_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_widx = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_ridx = '0;
   logic [31:0] reg_rdata;
   logic        dma_glb_en = 1'b1;
   logic        abort_in = 1'b0;
   logic        periph_req = 1'b0;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;

   logic [31:0] pv = 32'hA000_0000;
   logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
   int          nrd = 0, nwr = 0;

   always #2 clk = ~clk;

   dma_rpt_chan u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_widx(reg_widx),
      .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
      .dma_glb_en(dma_glb_en), .abort_in(abort_in), .periph_req(periph_req),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .irq(irq)
   );

   always @(posedge clk) begin
      if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         if (!bus_we) bus_rdata <= pv;
      end else begin
         bus_ack <= 1'b0;
      end
      if (bus_req && bus_ack) begin
         if (bus_we) begin
            last_waddr <= bus_addr;
            last_wdata <= bus_wdata;
            nwr <= nwr + 1;
         end else begin
            last_raddr <= bus_addr;
            nrd <= nrd + 1;
            pv <= pv + 32'd1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_widx = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] v);
      @(negedge clk);
      reg_ridx = idx;
      #1 v = reg_rdata;
   endtask

   task automatic kick();
      @(negedge clk); periph_req = 1'b1;
      @(negedge clk); periph_req = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [31:0] ctlw(input bit en, input bit ie, input bit hie,
                                        input logic [1:0] sm, input logic [1:0] dm,
                                        input logic [2:0] rpt, input bit hf,
                                        input bit ef, input bit ov);
      logic [31:0] w;
      w = '0;
      w[0] = en; w[1] = ie; w[2] = hie;
      w[4:3] = sm; w[6:5] = dm; w[9:7] = rpt;
      w[16] = hf; w[17] = ef; w[18] = ov;
      return w;
   endfunction

   initial begin
      #600000;
      if (!fin) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, dbase, exp_pv;
      int          n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         chk("R1 reset register", v, 32'd0);
      end
      chk("R1 reset irq", {31'd0, irq}, 32'd0);
      chk("R1 reset bus_req", {31'd0, bus_req}, 32'd0);

      // Sweep of repeat mode over counts 2..7, two full rounds each
      exp_pv = pv;
      for (int n = 2; n <= 7; n++) begin
         dbase = 32'h2000 + 32'(n) * 32'h100;
         wr(3'd5, 32'd0);
         wr(3'd0, 32'h1000);
         wr(3'd1, dbase);
         wr(3'd2, 32'(n));
         rd(3'd4, v); chk("R7 count backup loaded", v, 32'(n));
         rd(3'd3, v); chk("R7 dest backup loaded", v, dbase);
         wr(3'd5, ctlw(1, 1, 1, 2'b00, 2'b01, 3'b010, 0, 0, 0));
         for (int k = 1; k <= 2 * n; k++) begin
            int pos, rem;
            pos = (k - 1) % n;
            rem = n - pos - 1;
            kick();
            chk("R2 write data equals read data", last_wdata, exp_pv);
            exp_pv = exp_pv + 32'd1;
            chk("R3 source fixed", last_raddr, 32'h1000);
            chk("R3 destination increments by 4", last_waddr, dbase + 32'(4 * pos));
            rd(3'd2, v);
            chk("R6 count after transfer", v, (rem == 0) ? 32'(n) : 32'(rem));
            if (rem == 0) begin
               rd(3'd1, v); chk("R6 destination reloaded", v, dbase);
            end
            rd(3'd5, v);
            chk("R4 half-done flag", {31'd0, v[16]}, {31'd0, (rem == n / 2)});
            chk("R5 done flag", {31'd0, v[17]}, {31'd0, (rem == 0)});
            chk("R6 still enabled", {31'd0, v[0]}, 32'd1);
            chk("R10 irq follows flags", {31'd0, irq},
                {31'd0, (rem == n / 2) || (rem == 0)});
            wr(3'd5, ctlw(1, 1, 1, 2'b00, 2'b01, 3'b010, 0, 0, 0));
         end
      end

      // R3: incrementing source, decrementing destination, non-repeat
      wr(3'd5, 32'd0);
      wr(3'd0, 32'h3000);
      wr(3'd1, 32'h4000);
      wr(3'd2, 32'd5);
      wr(3'd5, ctlw(1, 0, 0, 2'b01, 2'b10, 3'b000, 0, 0, 0));
      kick();
      chk("R3 source first", last_raddr, 32'h3000);
      chk("R3 dest first", last_waddr, 32'h4000);
      kick();
      chk("R3 source incremented", last_raddr, 32'h3004);
      chk("R3 dest decremented", last_waddr, 32'h3FFC);
      rd(3'd2, v); chk("R2 count decremented", v, 32'd3);
      // R7: writes while enabled are ignored
      wr(3'd1, 32'h9999);
      wr(3'd2, 32'd77);
      rd(3'd1, v); chk("R7 dest write ignored while enabled", v, 32'h3FF8);
      rd(3'd2, v); chk("R7 count write ignored while enabled", v, 32'd3);
      rd(3'd3, v); chk("R7 dest backup unchanged", v, 32'h4000);
      // R5: non-repeat stops at terminal count
      kick(); kick(); kick();
      rd(3'd5, v);
      chk("R5 done flag", {31'd0, v[17]}, 32'd1);
      chk("R5 enable cleared", {31'd0, v[0]}, 32'd0);
      chk("R4 half flag at floor(5/2)", {31'd0, v[16]}, 32'd1);
      chk("R10 irq off without interrupt enable", {31'd0, irq}, 32'd0);
      n0 = nrd;
      kick();
      chk("R5 no bus activity after stop", 32'(nrd), 32'(n0));
      // R10 / R8
      wr(3'd5, ctlw(0, 1, 0, 2'b01, 2'b10, 3'b000, 1, 1, 0));
      chk("R10 irq from done flag", {31'd0, irq}, 32'd1);
      rd(3'd5, v); chk("R8 writing 1 keeps flags", v[17:16], 32'd3);
      wr(3'd5, ctlw(0, 1, 0, 2'b01, 2'b10, 3'b000, 1, 0, 0));
      chk("R10 half flag masked by half enable", {31'd0, irq}, 32'd0);
      rd(3'd5, v); chk("R8 writing 0 clears done", {31'd0, v[17]}, 32'd0);
      wr(3'd5, ctlw(0, 1, 1, 2'b01, 2'b10, 3'b000, 1, 0, 0));
      chk("R10 irq from half flag", {31'd0, irq}, 32'd1);

      // R8 same-cycle clear/set, then R9 overrun
      wr(3'd5, 32'd0);
      wr(3'd0, 32'h100);
      wr(3'd1, 32'h200);
      wr(3'd2, 32'd4);
      wr(3'd5, ctlw(1, 1, 1, 2'b00, 2'b01, 3'b010, 0, 0, 0));
      for (int k = 0; k < 5; k++) kick();
      rd(3'd5, v);
      chk("R8 both flags left set", v[17:16], 32'd3);
      @(negedge clk); periph_req = 1'b1;
      @(negedge clk); periph_req = 1'b0;
      repeat (3) @(negedge clk);
      reg_we = 1'b1; reg_widx = 3'd5;
      reg_wdata = ctlw(1, 1, 1, 2'b00, 2'b01, 3'b010, 0, 1, 0);
      chk("R12 write acknowledged in clear cycle", {29'd0, bus_req, bus_we, bus_ack}, 32'd7);
      @(negedge clk); reg_we = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      chk("R8 set wins over same-cycle clear", {31'd0, v[16]}, 32'd1);
      chk("R8 no overrun when cleared in same cycle", {31'd0, v[18]}, 32'd0);
      kick(); kick();
      rd(3'd5, v);
      chk("R9 overrun flag", {31'd0, v[18]}, 32'd1);
      chk("R9 enable cleared", {31'd0, v[0]}, 32'd0);
      rd(3'd2, v); chk("R9 no count reload", v, 32'd0);
      rd(3'd1, v); chk("R9 no dest reload", v, 32'h210);
      chk("R10 irq on overrun", {31'd0, irq}, 32'd1);
      n0 = nrd;
      kick();
      chk("R9 halted channel idle", 32'(nrd), 32'(n0));

      // R11: global enable and abort
      wr(3'd5, 32'd0);
      wr(3'd2, 32'd3);
      wr(3'd5, ctlw(1, 0, 0, 2'b00, 2'b01, 3'b010, 0, 0, 0));
      dma_glb_en = 1'b0;
      n0 = nrd;
      kick();
      chk("R11 no start with global enable low", 32'(nrd), 32'(n0));
      rd(3'd5, v); chk("R11 enable kept", {31'd0, v[0]}, 32'd1);
      dma_glb_en = 1'b1;
      kick();
      chk("R11 start after global enable", 32'(nrd), 32'(n0 + 1));
      @(negedge clk); abort_in = 1'b1;
      @(negedge clk); abort_in = 1'b0;
      rd(3'd5, v); chk("R11 abort clears enable", {31'd0, v[0]}, 32'd0);
      n0 = nrd;
      kick();
      chk("R11 no start after abort", 32'(nrd), 32'(n0));

      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule